// File: doc/BRIEF.md
# Infrared Run-Length Receive Sampler

This block watches a demodulated infrared line and turns it into a stream of run-length samples. Each sample is one byte. The top bit marks the run as a space, and the lower seven bits give how long the run lasted, counted in whole sample periods. A sample period is a host-chosen number of microsecond ticks. The line is first synchronised, then its polarity can be flipped, and then it is measured. A sample is committed each time the corrected level changes. A sample is also committed when a run grows too long for seven bits.

Samples go into an eight-byte store that works as two four-byte halves used in turn. When the fourth byte of a half is written, the block raises a pending flag and shows which half is complete. Writing then moves on into the other half. The host reads the bytes through a plain address/data read port and clears the pending flag with a one-cycle strobe. An interrupt output combines the pending flag with an optional overflow event.

Top module: `irrl_sampler`

## Requirements
- R1: After reset, rx_pend, irq and ready_half are all 0, and every buffer byte reads 0.
- R2: Each sample byte has bit 7 = 1 for a space (corrected level 0) and bit 7 = 0 for a mark (corrected level 1). Bits 6:0 hold the number of complete sample periods that elapsed in that run. A sample is committed when the corrected level changes.
- R3: A sample period is cfg_period microsecond ticks. The period timer restarts at every level change, so any partial period at the end of a run is discarded.
- R4: When a run reaches 127 periods, a sample with duration 127 and the run's own space flag is committed at once. Counting then restarts from 0 in a new sample of the same polarity.
- R5: With cfg_invert = 1, the corrected level is the inverse of the raw line.
- R6: Bytes 0-3 (rd_addr bit 2 = 0) form half 0 and bytes 4-7 form half 1. Writing begins at half 0, byte 0, and fills in order. The fourth write into a half sets rx_pend and sets ready_half to that half. Writing then continues in the other half.
- R7: A one-cycle pend_clr clears rx_pend and the overflow flag on the next clock edge.
- R8: irq is 1 only when cfg_irq_en = 1 and either rx_pend or the overflow flag is set.
- R9: A saturated (R4) sample sets the overflow flag only while cfg_ovf_irq_en = 1.
- R10: While cfg_rx_en = 0, no sample is committed and the buffer and flags are unchanged. On enable, the first run starts at the current level with a count of 0.
- R11: cfg_period = 0 selects the default period of 50 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_raw | input | 1 | Asynchronous demodulated IR line |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_ovf_irq_en | input | 1 | Interrupt on saturated sample |
| cfg_invert | input | 1 | Reverse input polarity |
| cfg_period | input | 8 | Sample period in ticks (0 = default 50) |
| rd_addr | input | 3 | Buffer byte address |
| rd_data | output | 8 | Buffer byte at rd_addr |
| ready_half | output | 1 | Half holding the last completed packet |
| rx_pend | output | 1 | Packet-ready flag |
| pend_clr | input | 1 | Clear strobe for the pending flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four-byte halves, two synchroniser stages, an eight-bit period field, and a default period of 50. Because the host can program a period of one tick, a 127-period saturation costs only 127 ticks, so both overflow cases are cheap to reach. Five packets are built across both halves and both polarities. They include zero-length runs, discarded partial periods, a disabled stretch and the default-period selection, so that ready_half alternates and each byte value is computed from the tick counts.

// File: rtl/irrl_pkg.sv
// Shared constants and the sample type of the IR run-length sampler.
// Assumes a 7-bit duration field plus one space flag per byte.
package irrl_pkg;
    localparam int DUR_W    = 7;
    localparam int SAMPLE_W = DUR_W + 1;
    localparam int DUR_MAX  = (1 << DUR_W) - 1;

    typedef struct packed {
        logic             space;
        logic [DUR_W-1:0] dur;
    } sample_t;
endpackage

// File: rtl/irrl_sync.sv
// Multi-stage synchroniser for the asynchronous IR line.
// Assumes STAGES >= 2; output is delayed by STAGES clocks.
module irrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/irrl_period_timer.sv
// Divides microsecond ticks into sample-period strobes.
// Assumes clear is held while receive is off and pulsed on level change.
module irrl_period_timer #(
    parameter int PER_W      = 8,
    parameter int DEF_PERIOD = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             us_tick,
    input  logic [PER_W-1:0] cfg_period,
    output logic             period_tick
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] eff_period;

    // Period 0 selects the built-in default.
    always_comb begin
        eff_period = (cfg_period == '0) ? PER_W'(DEF_PERIOD) : cfg_period;
    end

    assign period_tick = !clear && us_tick && (cnt >= eff_period - PER_W'(1));

    // Count ticks within the current period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt <= '0;
        else if (period_tick) cnt <= '0;
        else if (us_tick)     cnt <= cnt + PER_W'(1);
    end

    // R3
    period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> (cnt == '0));
endmodule

// File: rtl/irrl_run_counter.sv
// Measures runs of the corrected IR level and emits samples on level
// change or saturation. Assumes period_tick never asserts during clear.
module irrl_run_counter
    import irrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rx_en,
    input  logic    level,
    input  logic    period_tick,
    output logic    commit,
    output logic    sat_commit,
    output logic    timer_clear,
    output sample_t sample
);
    logic             cur_lvl;
    logic [DUR_W-1:0] run_len;
    logic             change;

    // Detect a change and a count reaching full scale.
    always_comb begin
        change      = rx_en && (level != cur_lvl);
        sat_commit  = rx_en && !change && period_tick &&
                      (run_len == DUR_W'(DUR_MAX - 1));
        commit      = change || sat_commit;
        timer_clear = !rx_en || change;
        sample.space = !cur_lvl;
        sample.dur   = change ? run_len : DUR_W'(DUR_MAX);
    end

    // Track the level of the current run and its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= 1'b0;
            run_len <= '0;
        end else if (!rx_en || change) begin
            cur_lvl <= level;
            run_len <= '0;
        end else if (period_tick) begin
            run_len <= sat_commit ? '0 : run_len + DUR_W'(1);
        end
    end

    // R4
    sat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_commit |=> (run_len == '0) && (cur_lvl == $past(cur_lvl)));
    // R2
    change_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> (cur_lvl == $past(level)) && (run_len == '0));
endmodule

// File: rtl/irrl_pingpong_buf.sv
// Two-half sample store with packet-ready and overflow flags.
// Assumes one write per cycle at most; the read port is combinational.
module irrl_pingpong_buf
    import irrl_pkg::*;
#(
    parameter int HALF_DEPTH = 4,
    localparam int IDX_W     = $clog2(HALF_DEPTH),
    localparam int ADDR_W    = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  sample_t             wr_data,
    input  logic                sat_evt,
    input  logic                ovf_en,
    input  logic                pend_clr,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                ready_half,
    output logic                rx_pend,
    output logic                ovf_pend
);
    logic [SAMPLE_W-1:0] mem [2*HALF_DEPTH];
    logic                wr_half;
    logic [IDX_W-1:0]    idx;
    logic                half_done;

    assign half_done = wr_en && (idx == IDX_W'(HALF_DEPTH - 1));
    assign rd_data   = mem[rd_addr];

    // Store committed samples; every byte starts empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2*HALF_DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[{wr_half, idx}] <= wr_data;
        end
    end

    // Advance the write position and swap halves when one fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_half    <= 1'b0;
            idx        <= '0;
            ready_half <= 1'b0;
        end else if (half_done) begin
            ready_half <= wr_half;
            wr_half    <= !wr_half;
            idx        <= '0;
        end else if (wr_en) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // Packet-ready and overflow flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pend  <= 1'b0;
            ovf_pend <= 1'b0;
        end else begin
            if (half_done)     rx_pend <= 1'b1;
            else if (pend_clr) rx_pend <= 1'b0;
            if (sat_evt && ovf_en) ovf_pend <= 1'b1;
            else if (pend_clr)     ovf_pend <= 1'b0;
        end
    end

    // R6
    half_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_done |=> rx_pend && (idx == '0) && (ready_half != wr_half));
    // R6
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_pend) |-> $past(half_done));
    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !half_done) |=> !rx_pend);
    // R9
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_pend) |-> $past(ovf_en && sat_evt));
endmodule

// File: rtl/irrl_sampler.sv
// Top of the IR run-length receive sampler: synchronise, correct polarity,
// measure runs, store samples in two halves, raise the interrupt.
// Assumes us_tick is a single-cycle pulse in the clk domain.
module irrl_sampler
    import irrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PER_W       = 8,
    parameter int DEF_PERIOD  = 50,
    parameter int HALF_DEPTH  = 4,
    localparam int ADDR_W     = $clog2(HALF_DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ir_raw,
    input  logic                us_tick,
    input  logic                cfg_rx_en,
    input  logic                cfg_irq_en,
    input  logic                cfg_ovf_irq_en,
    input  logic                cfg_invert,
    input  logic [PER_W-1:0]    cfg_period,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                ready_half,
    output logic                rx_pend,
    input  logic                pend_clr,
    output logic                irq
);
    logic    ir_s;
    logic    level;
    logic    period_tick;
    logic    commit;
    logic    sat_commit;
    logic    timer_clear;
    logic    ovf_pend;
    sample_t sample;

    irrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(ir_raw), .d_out(ir_s)
    );

    assign level = ir_s ^ cfg_invert;

    irrl_period_timer #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(timer_clear), .us_tick(us_tick),
        .cfg_period(cfg_period), .period_tick(period_tick)
    );

    irrl_run_counter u_run (
        .clk(clk), .rst_n(rst_n), .rx_en(cfg_rx_en), .level(level),
        .period_tick(period_tick), .commit(commit), .sat_commit(sat_commit),
        .timer_clear(timer_clear), .sample(sample)
    );

    irrl_pingpong_buf #(.HALF_DEPTH(HALF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_data(sample),
        .sat_evt(sat_commit), .ovf_en(cfg_ovf_irq_en), .pend_clr(pend_clr),
        .rd_addr(rd_addr), .rd_data(rd_data), .ready_half(ready_half),
        .rx_pend(rx_pend), .ovf_pend(ovf_pend)
    );

    assign irq = cfg_irq_en && (rx_pend || ovf_pend);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_en |-> !commit);
endmodule

// File: tb/irrl_sampler_bench.sv
module irrl_sampler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_raw = 1'b0;
    logic       us_tick = 1'b0;
    logic       cfg_rx_en = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       cfg_ovf_irq_en = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [7:0] cfg_period = 8'd0;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       ready_half, rx_pend, irq, pend_clr;

    logic       use_main = 1'b0;
    logic [2:0] main_addr = 3'd0, mon_addr = 3'd0;
    logic       mon_clr = 1'b0, drv_clr = 1'b0;
    assign rd_addr  = use_main ? main_addr : mon_addr;
    assign pend_clr = mon_clr | drv_clr;

    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q [$];
    logic       exp_half = 1'b0;
    bit         have_prev = 1'b0;
    logic       prev_sp = 1'b0;
    int         prev_t = 0;

    always #10 clk = ~clk;

    irrl_sampler u_irrl_sampler (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .us_tick(us_tick),
        .cfg_rx_en(cfg_rx_en), .cfg_irq_en(cfg_irq_en),
        .cfg_ovf_irq_en(cfg_ovf_irq_en), .cfg_invert(cfg_invert),
        .cfg_period(cfg_period), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready_half(ready_half), .rx_pend(rx_pend), .pend_clr(pend_clr),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int eff_period();
        return (cfg_period == 8'd0) ? 50 : int'(cfg_period);
    endfunction

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    // Driver: start a run of the corrected level 'mark' lasting nt ticks, push expectations.
    task automatic run_lvl(input logic mark, input int nt);
        int t;
        if (have_prev) exp_q.push_back({prev_sp, 7'(prev_t)});
        @(negedge clk) ir_raw = mark ^ cfg_invert;
        repeat (6) @(negedge clk);
        t = nt / eff_period();
        for (int k = 0; k < t / 127; k++) exp_q.push_back({!mark, 7'h7F});
        tick_n(nt);
        have_prev = 1'b1;
        prev_sp   = !mark;
        prev_t    = t % 127;
    endtask

    // Monitor: read each completed packet and compare against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_pend && !done) begin
                chk(ready_half == exp_half, "R6 ready_half", ready_half, exp_half);
                chk(irq == cfg_irq_en, "R8 irq with packet", irq, cfg_irq_en);
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] e;
                    mon_addr = {ready_half, 2'(k)};
                    #1;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected sample", rd_data, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(rd_data == e, "R2/R4 sample byte", rd_data, e);
                    end
                end
                exp_half = !exp_half;
                mon_clr = 1'b1;
                @(negedge clk) mon_clr = 1'b0;
                chk(rx_pend == 1'b0, "R7 clear pending", rx_pend, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_pend == 0, "R1 rx_pend", rx_pend, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(ready_half == 0, "R1 ready_half", ready_half, 0);
        use_main = 1'b1; main_addr = 3'd5; #1;
        chk(rd_data == 0, "R1 empty buffer", rd_data, 0);
        use_main = 1'b0;

        // Phase A/B: period 2, no inversion (R2, R3, R6, R8)
        cfg_period = 8'd2; cfg_irq_en = 1'b1;
        ir_raw = 1'b1; repeat (6) @(negedge clk);
        cfg_rx_en = 1'b1; repeat (2) @(negedge clk);
        run_lvl(1'b1, 10);
        run_lvl(1'b0, 7);
        run_lvl(1'b1, 4);
        run_lvl(1'b0, 20);
        run_lvl(1'b1, 3);
        run_lvl(1'b0, 1);
        run_lvl(1'b1, 6);
        run_lvl(1'b0, 9);
        run_lvl(1'b1, 2);
        repeat (10) @(negedge clk);

        // R10: disabled, line activity must not change anything
        cfg_rx_en = 1'b0; have_prev = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) ir_raw = ~ir_raw;
            repeat (4) @(negedge clk);
            tick_n(5);
        end
        repeat (5) @(negedge clk);
        chk(rx_pend == 0, "R10 no packet while disabled", rx_pend, 0);
        chk(ready_half == 1, "R10 ready_half held", ready_half, 1);
        use_main = 1'b1; main_addr = 3'd0; #1;
        chk(rd_data == 8'h05, "R10 buffer unchanged", rd_data, 8'h05);
        use_main = 1'b0;

        // Phase D: inverted polarity, period 3, irq disabled (R5, R8)
        cfg_invert = 1'b1; cfg_period = 8'd3; cfg_irq_en = 1'b0;
        @(negedge clk) ir_raw = 1'b0;
        repeat (6) @(negedge clk);
        cfg_rx_en = 1'b1; repeat (2) @(negedge clk);
        run_lvl(1'b1, 9);
        run_lvl(1'b0, 10);
        run_lvl(1'b1, 2);
        run_lvl(1'b0, 3);
        run_lvl(1'b1, 0);

        // Phase E: saturation with overflow interrupt (R4, R9, R7)
        cfg_period = 8'd1; cfg_irq_en = 1'b1; cfg_ovf_irq_en = 1'b1;
        run_lvl(1'b0, 130);
        repeat (2) @(negedge clk);
        chk(irq == 1, "R9 overflow raises irq", irq, 1);
        chk(rx_pend == 0, "R9 no packet yet", rx_pend, 0);
        drv_clr = 1'b1;
        @(negedge clk) drv_clr = 1'b0;
        chk(irq == 0, "R7 clear drops overflow", irq, 0);
        run_lvl(1'b1, 5);
        run_lvl(1'b0, 0);

        // Phase F: saturation without overflow enable, then default period (R9, R11)
        cfg_ovf_irq_en = 1'b0;
        run_lvl(1'b1, 127);
        repeat (2) @(negedge clk);
        chk(irq == 0, "R9 no overflow irq when disabled", irq, 0);
        cfg_period = 8'd0;
        run_lvl(1'b0, 100);   // R11: 100 ticks at default 50 -> 2 periods
        run_lvl(1'b1, 0);

        for (int i = 0; i < 2000; i++) begin
            if (exp_q.size() == 0 && !rx_pend) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all packets delivered", exp_q.size(), 0);
        chk(exp_half == 1'b1, "R6 five packets alternate", exp_half, 1);
        finish_up();
    end
endmodule